// File: doc/BRIEF.md
# Emulation Trap Detect and Entry

This block sits at the retire point of a 32-bit core. For each retiring instruction it looks at decode flags from the decoder, at the special-register number and attributes of a special-register move, at the machine state register and at the floating-point exception summary bit. From these it decides whether one of three traps is taken: the software-emulation trap, the floating-point-enabled program trap or the floating-point assist trap. When a trap is taken, it raises one strobe and a matching one-hot cause code in the same cycle.

On the clock edge that ends a trapping cycle, the block captures the trap-entry values of the two save/restore registers and of the new machine state register. It holds them until the next trap. Vector generation, pipeline flush and the decode of opcodes are left to neighbouring blocks. Bit numbers in this brief are LSB-0 indices of the 32-bit words. The MSB-0 position used by the architecture is given in brackets.

Top module: `emu_trap_entry`

## Requirements
- R1: With `instValid` high, any of `illegalOp`, `unimplOpt` or `fpInstr` raises `emuTrap` in the same cycle, and `trapCause` bit 0 is set.
- R2: A special-register move (`sprMove`) to a register that is not implemented (`sprImpl` low) and is on-core (`sprOffCore` low) raises `emuTrap` whatever the value of `sprNum[0]`.
- R3: An unimplemented off-core special-register move raises `emuTrap` only when `sprNum[0]` is 0 or the privilege bit `msrIn[14]` [MSB-0 17] is 0. Otherwise it raises no trap.
- R4: `fpscrMove`, `msrMove` or `rfiOp` raises `progTrap` (`trapCause` bit 1) when (`msrIn[11]` [FE0, MSB-0 20] OR `msrIn[8]` [FE1, MSB-0 23]) AND `fpscrFex` is 1.
- R5: `fpArith` raises `assistTrap` (`trapCause` bit 2) under that same enable condition, and never the program trap.
- R6: At most one strobe is raised per cycle, with priority emulation, then program, then assist. `trapCause` is one-hot and equals {assist, program, emulation}, and it is all zero when no trap is taken or `instValid` is low.
- R7: After a trapping cycle, `srr0Q` holds that cycle's `effAddr`.
- R8: After a trapping cycle, `srr1Q[31:16]` (MSB-0 0..15, which covers the cleared fields 1..4 and 10..15) is zero, and `srr1Q[15:0]` is `msrIn[15:0]`.
- R9: After a trapping cycle, `msrQ` keeps `msrIn[6]` (interrupt prefix, MSB-0 25) and `msrIn[12]` (machine-check enable, MSB-0 19). It takes `msrQ[0]` (little-endian, MSB-0 31) from `msrIn[16]` (interrupt little-endian, MSB-0 15), and all its other bits are zero.
- R10: `srr1Q[1]` (MSB-0 30) changes only when a trap loads it from the recoverable bit `msrIn[1]`.
- R11: With no trap, `srr0Q`, `srr1Q` and `msrQ` keep their values. A synchronous `rst` clears all three to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | 1 | An instruction retires this cycle |
| illegalOp | input | 1 | Illegal opcode |
| unimplOpt | input | 1 | Unimplemented optional instruction |
| fpInstr | input | 1 | Floating-point instruction to be emulated |
| sprMove | input | 1 | Move to or from a special register |
| sprImpl | input | 1 | The addressed special register exists |
| sprOffCore | input | 1 | The addressed special register is off-core |
| sprNum | input | SPR_W | Special-register number |
| fpscrMove | input | 1 | Move to the FP status register |
| msrMove | input | 1 | Move to the machine state register |
| rfiOp | input | 1 | Return from interrupt |
| fpArith | input | 1 | Floating-point arithmetic executed in hardware |
| fpscrFex | input | 1 | FP enabled-exception summary bit |
| msrIn | input | 32 | Machine state register seen at retire |
| effAddr | input | ADDR_W | Effective address of the retiring instruction |
| emuTrap | output | 1 | Emulation trap strobe |
| progTrap | output | 1 | FP-enabled program trap strobe |
| assistTrap | output | 1 | FP assist trap strobe |
| trapCause | output | 3 | One-hot cause: bit0 emulation, bit1 program, bit2 assist |
| srr0Q | output | ADDR_W | Captured save/restore register 0 |
| srr1Q | output | 32 | Captured save/restore register 1 |
| msrQ | output | 32 | Captured new machine state register |

## Verification
The emulation trap can coincide with either floating-point trap: an illegal opcode or an emulated FP instruction can arrive together with an MSR move or an FP arithmetic flag while the FP enable condition is true. An FP arithmetic flag can also coincide with an FPSCR move. The stimulus table raises these collisions on purpose, alongside single-cause rows. For each row the bench judges that exactly the higher-priority strobe and cause bit appear. It also checks that the captured registers then hold values built from that cycle's inputs. No-trap rows sit between trapping rows, so that the hold of all three registers is also seen.

// File: rtl/emu_trap_pkg.sv
package emu_trap_pkg;

  localparam int XLEN = 32;
  localparam int CAUSE_W = 3;

  // LSB-0 indices of machine state bits used by the block
  localparam int MSR_LE  = 0;
  localparam int MSR_RI  = 1;
  localparam int MSR_IP  = 6;
  localparam int MSR_FE1 = 8;
  localparam int MSR_FE0 = 11;
  localparam int MSR_ME  = 12;
  localparam int MSR_PR  = 14;
  localparam int MSR_ILE = 16;

  // Cause bit positions
  localparam int CAUSE_EMU    = 0;
  localparam int CAUSE_PROG   = 1;
  localparam int CAUSE_ASSIST = 2;

  typedef struct packed {
    logic take;
    logic emu;
    logic prog;
    logic assist;
  } trapCtl_t;

endpackage

// File: rtl/emu_trap_ctrl.sv
module emu_trap_ctrl
  import emu_trap_pkg::*;
(
  input  logic               instValid,
  input  logic               illegalOp,
  input  logic               unimplOpt,
  input  logic               fpInstr,
  input  logic               sprMove,
  input  logic               sprImpl,
  input  logic               sprOffCore,
  input  logic               sprLsb,
  input  logic               fpscrMove,
  input  logic               msrMove,
  input  logic               rfiOp,
  input  logic               fpArith,
  input  logic               fpscrFex,
  input  logic [XLEN-1:0]    msrIn,
  output trapCtl_t           ctl,
  output logic [CAUSE_W-1:0] cause
);

  logic fpEnabled;
  logic sprTrap;
  logic emuReq;
  logic progReq;
  logic assistReq;

  always_comb begin
    fpEnabled = (msrIn[MSR_FE0] | msrIn[MSR_FE1]) & fpscrFex;
    // on-core: always; off-core: only when low number bit or privilege is clear
    sprTrap   = sprMove & ~sprImpl & (~sprOffCore | ~sprLsb | ~msrIn[MSR_PR]);
    emuReq    = instValid & (illegalOp | unimplOpt | fpInstr | sprTrap);
    progReq   = instValid & (fpscrMove | msrMove | rfiOp) & fpEnabled;
    assistReq = instValid & fpArith & fpEnabled;
  end

  always_comb begin
    ctl = '0;
    if (emuReq) begin
      ctl.emu = 1'b1;
    end else if (progReq) begin
      ctl.prog = 1'b1;
    end else if (assistReq) begin
      ctl.assist = 1'b1;
    end
    ctl.take = ctl.emu | ctl.prog | ctl.assist;
  end

  always_comb begin
    cause               = '0;
    cause[CAUSE_EMU]    = ctl.emu;
    cause[CAUSE_PROG]   = ctl.prog;
    cause[CAUSE_ASSIST] = ctl.assist;
  end

endmodule

// File: rtl/emu_trap_dp.sv
module emu_trap_dp
  import emu_trap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  trapCtl_t          ctl,
  input  logic [XLEN-1:0]   msrIn,
  input  logic [ADDR_W-1:0] effAddr,
  output logic [ADDR_W-1:0] srr0Q,
  output logic [XLEN-1:0]   srr1Q,
  output logic [XLEN-1:0]   msrQ
);

  localparam int COPY_W = XLEN / 2;

  logic [XLEN-1:0] srr1Next;
  logic [XLEN-1:0] msrNext;

  // Save/restore 1: upper half cleared, lower half copied from machine state
  always_comb begin
    srr1Next = '0;
    srr1Next[COPY_W-1:0] = msrIn[COPY_W-1:0];
  end

  // New machine state: per-bit selection, built bit by bit
  for (genvar b = 0; b < XLEN; b++) begin : g_msr
    if (b == MSR_IP || b == MSR_ME) begin : g_keep
      assign msrNext[b] = msrIn[b];
    end else if (b == MSR_LE) begin : g_le
      assign msrNext[b] = msrIn[MSR_ILE];
    end else begin : g_clr
      assign msrNext[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      srr0Q <= '0;
      srr1Q <= '0;
      msrQ  <= '0;
    end else if (ctl.take) begin
      srr0Q <= effAddr;
      srr1Q <= srr1Next;
      msrQ  <= msrNext;
    end
  end

endmodule

// File: rtl/emu_trap_entry.sv
module emu_trap_entry
  import emu_trap_pkg::*;
#(
  parameter int SPR_W  = 10,
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instValid,
  input  logic               illegalOp,
  input  logic               unimplOpt,
  input  logic               fpInstr,
  input  logic               sprMove,
  input  logic               sprImpl,
  input  logic               sprOffCore,
  input  logic [SPR_W-1:0]   sprNum,
  input  logic               fpscrMove,
  input  logic               msrMove,
  input  logic               rfiOp,
  input  logic               fpArith,
  input  logic               fpscrFex,
  input  logic [31:0]        msrIn,
  input  logic [ADDR_W-1:0]  effAddr,
  output logic               emuTrap,
  output logic               progTrap,
  output logic               assistTrap,
  output logic [2:0]         trapCause,
  output logic [ADDR_W-1:0]  srr0Q,
  output logic [31:0]        srr1Q,
  output logic [31:0]        msrQ
);

  trapCtl_t ctl;

  emu_trap_ctrl u_ctrl (
    .instValid (instValid),
    .illegalOp (illegalOp),
    .unimplOpt (unimplOpt),
    .fpInstr   (fpInstr),
    .sprMove   (sprMove),
    .sprImpl   (sprImpl),
    .sprOffCore(sprOffCore),
    .sprLsb    (sprNum[0]),
    .fpscrMove (fpscrMove),
    .msrMove   (msrMove),
    .rfiOp     (rfiOp),
    .fpArith   (fpArith),
    .fpscrFex  (fpscrFex),
    .msrIn     (msrIn),
    .ctl       (ctl),
    .cause     (trapCause)
  );

  emu_trap_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .msrIn  (msrIn),
    .effAddr(effAddr),
    .srr0Q  (srr0Q),
    .srr1Q  (srr1Q),
    .msrQ   (msrQ)
  );

  assign emuTrap    = ctl.emu;
  assign progTrap   = ctl.prog;
  assign assistTrap = ctl.assist;

endmodule

// File: rtl/emu_trap_chk.sv
module emu_trap_chk #(
  parameter int SPR_W  = 10,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              instValid,
  input logic              illegalOp,
  input logic              unimplOpt,
  input logic              fpInstr,
  input logic              sprMove,
  input logic              sprImpl,
  input logic              sprOffCore,
  input logic [SPR_W-1:0]  sprNum,
  input logic              fpscrMove,
  input logic              msrMove,
  input logic              rfiOp,
  input logic              fpArith,
  input logic              fpscrFex,
  input logic [31:0]       msrIn,
  input logic [ADDR_W-1:0] effAddr,
  input logic              emuTrap,
  input logic              progTrap,
  input logic              assistTrap,
  input logic [2:0]        trapCause,
  input logic [ADDR_W-1:0] srr0Q,
  input logic [31:0]       srr1Q,
  input logic [31:0]       msrQ
);

  logic anyTrap;
  assign anyTrap = emuTrap | progTrap | assistTrap;

  a_r1_emu_on_bad_op: assert property (@(posedge clk) disable iff (rst)
    instValid && (illegalOp || unimplOpt || fpInstr) |-> emuTrap && trapCause[0]);

  a_r2_oncore_spr: assert property (@(posedge clk) disable iff (rst)
    instValid && sprMove && !sprImpl && !sprOffCore |-> emuTrap);

  a_r3_offcore_quiet: assert property (@(posedge clk) disable iff (rst)
    instValid && sprMove && !sprImpl && sprOffCore && sprNum[0] && msrIn[14]
    && !illegalOp && !unimplOpt && !fpInstr |-> !emuTrap);

  a_r4_prog_raised: assert property (@(posedge clk) disable iff (rst)
    instValid && msrMove && (msrIn[11] || msrIn[8]) && fpscrFex && !emuTrap |-> progTrap);

  a_r5_assist_not_prog: assert property (@(posedge clk) disable iff (rst)
    instValid && fpArith && !fpscrMove && !msrMove && !rfiOp |-> !progTrap);

  a_r6_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(trapCause) && $countones({emuTrap, progTrap, assistTrap}) <= 1);

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !instValid |-> trapCause == 3'b000 && !anyTrap);

  a_r7_srr0_load: assert property (@(posedge clk) disable iff (rst)
    anyTrap |=> srr0Q == $past(effAddr));

  a_r8_srr1_load: assert property (@(posedge clk) disable iff (rst)
    anyTrap |=> srr1Q == {16'h0000, $past(msrIn[15:0])});

  a_r9_msr_le: assert property (@(posedge clk) disable iff (rst)
    anyTrap |=> msrQ[0] == $past(msrIn[16]) && msrQ[6] == $past(msrIn[6])
             && msrQ[12] == $past(msrIn[12]));

  a_r10_ri_hold: assert property (@(posedge clk) disable iff (rst)
    !anyTrap |=> $stable(srr1Q[1]));

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !anyTrap |=> $stable(srr0Q) && $stable(srr1Q) && $stable(msrQ));

  a_r11_reset_clear: assert property (@(posedge clk)
    rst |=> srr0Q == '0 && srr1Q == '0 && msrQ == '0);

endmodule

bind emu_trap_entry emu_trap_chk #(.SPR_W(SPR_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .instValid(instValid), .illegalOp(illegalOp),
  .unimplOpt(unimplOpt), .fpInstr(fpInstr), .sprMove(sprMove), .sprImpl(sprImpl),
  .sprOffCore(sprOffCore), .sprNum(sprNum), .fpscrMove(fpscrMove), .msrMove(msrMove),
  .rfiOp(rfiOp), .fpArith(fpArith), .fpscrFex(fpscrFex), .msrIn(msrIn),
  .effAddr(effAddr), .emuTrap(emuTrap), .progTrap(progTrap), .assistTrap(assistTrap),
  .trapCause(trapCause), .srr0Q(srr0Q), .srr1Q(srr1Q), .msrQ(msrQ)
);

// File: tb/tb_emu_trap_entry.sv
module tb_emu_trap_entry;

  localparam int CLK_PERIOD = 10;
  localparam int SPR_W = 10;
  localparam int ADDR_W = 32;
  localparam int NVEC = 18;

  // illegal,unimpl,fp | sprMove,impl,off | lsb,priv | fpscr,msr,rfi,arith | fe0,fe1,fex | cause
  localparam logic [17:0] VECS [NVEC] = '{
    18'b100_000_00_0000_000_001,  // R1 illegal
    18'b010_000_00_0000_000_001,  // R1 optional
    18'b001_000_00_0000_000_001,  // R1 fp
    18'b000_100_11_0000_000_001,  // R2 on-core, lsb 1, priv 1
    18'b000_101_11_0000_000_000,  // R3 off-core quiet
    18'b000_101_01_0000_000_001,  // R3 lsb 0
    18'b000_101_10_0000_000_001,  // R3 priv 0
    18'b000_110_00_0000_000_000,  // R2 implemented
    18'b000_000_00_1000_101_010,  // R4 fpscr move
    18'b000_000_00_0100_011_010,  // R4 msr move
    18'b000_000_00_0010_100_000,  // R4 rfi, no summary
    18'b000_000_00_0010_001_000,  // R4 rfi, no enable
    18'b000_000_00_0001_101_100,  // R5 assist
    18'b000_000_00_1001_011_010,  // R6 program beats assist
    18'b100_000_00_0100_101_001,  // R6 emulation beats program
    18'b001_000_00_0001_101_001,  // R6 emulation beats assist
    18'b000_000_00_0001_110_000,  // R5 no summary
    18'b000_000_01_0000_111_000   // R6 nothing
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic instValid = 1'b0, illegalOp = 1'b0, unimplOpt = 1'b0, fpInstr = 1'b0;
  logic sprMove = 1'b0, sprImpl = 1'b0, sprOffCore = 1'b0;
  logic [SPR_W-1:0] sprNum = '0;
  logic fpscrMove = 1'b0, msrMove = 1'b0, rfiOp = 1'b0, fpArith = 1'b0, fpscrFex = 1'b0;
  logic [31:0] msrIn = '0;
  logic [ADDR_W-1:0] effAddr = '0;
  logic emuTrap, progTrap, assistTrap;
  logic [2:0] trapCause;
  logic [ADDR_W-1:0] srr0Q;
  logic [31:0] srr1Q, msrQ;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [31:0] expSrr0 = '0, expSrr1 = '0, expMsr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  emu_trap_entry #(.SPR_W(SPR_W), .ADDR_W(ADDR_W)) dut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [17:0] v, input logic [31:0] msr, input logic [31:0] ea);
    instValid  = 1'b1;
    illegalOp  = v[17]; unimplOpt = v[16]; fpInstr = v[15];
    sprMove    = v[14]; sprImpl = v[13]; sprOffCore = v[12];
    sprNum     = {{(SPR_W-1){1'b1}}, v[11]};
    fpscrMove  = v[9]; msrMove = v[8]; rfiOp = v[7]; fpArith = v[6];
    fpscrFex   = v[3];
    msrIn      = msr;
    msrIn[14]  = v[10];
    msrIn[11]  = v[5];
    msrIn[8]   = v[4];
    effAddr    = ea;
  endtask

  task automatic idle();
    instValid = 1'b0; illegalOp = 1'b0; unimplOpt = 1'b0; fpInstr = 1'b0;
    sprMove = 1'b0; sprImpl = 1'b0; sprOffCore = 1'b0; sprNum = '0;
    fpscrMove = 1'b0; msrMove = 1'b0; rfiOp = 1'b0; fpArith = 1'b0; fpscrFex = 1'b0;
  endtask

  task automatic model(input logic [31:0] msr, input logic [31:0] ea);
    expSrr0 = ea;
    expSrr1 = {16'h0000, msr[15:0]};
    expMsr = '0;
    expMsr[6] = msr[6];
    expMsr[12] = msr[12];
    expMsr[0] = msr[16];
  endtask

  task automatic checkRegs(input string req);
    check(srr0Q == expSrr0, {req, " srr0"}, srr0Q, expSrr0);
    check(srr1Q == expSrr1, {req, " srr1"}, srr1Q, expSrr1);
    check(msrQ == expMsr, {req, " msr"}, msrQ, expMsr);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R11 reset state
    check(trapCause == 3'b000, "R11 reset cause", {29'b0, trapCause}, 32'h0);
    checkRegs("R11 reset");

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] msr;
      logic [31:0] ea;
      logic [2:0] expCause;
      @(negedge clk);
      msr = 32'h9E37_79B9 ^ (i * 32'h0101_3377);
      ea  = 32'h1000_0000 + i * 4;
      drive(VECS[i], msr, ea);
      expCause = VECS[i][2:0];
      #1;
      check(trapCause == expCause && {assistTrap, progTrap, emuTrap} == expCause,
            $sformatf("R1-table row %0d cause (R2 R3 R4 R5 R6)", i),
            {29'b0, trapCause}, {29'b0, expCause});
      if (expCause != 3'b000) model(msrIn, ea);
      @(posedge clk);
      #1;
      checkRegs(expCause != 3'b000 ? "R7 R8 R9 trap load" : "R11 hold");
    end

    // R6: instValid low suppresses a trap
    @(negedge clk);
    drive(18'b100_000_00_0000_000_001, 32'hFFFF_FFFF, 32'hDEAD_0000);
    instValid = 1'b0;
    #1;
    check(trapCause == 3'b000 && !emuTrap, "R6 invalid quiet", {29'b0, trapCause}, 32'h0);
    @(posedge clk); #1;
    checkRegs("R6 invalid no load");

    // R10: recoverable bit captured then held
    @(negedge clk);
    drive(18'b010_000_00_0000_000_001, 32'h0000_0002, 32'h2000_0000);
    #1;
    model(msrIn, 32'h2000_0000);
    @(posedge clk); #1;
    check(srr1Q[1] == 1'b1, "R10 ri loaded", {31'b0, srr1Q[1]}, 32'h1);
    @(negedge clk);
    drive(18'b000_000_00_0000_000_000, 32'h0000_0000, 32'h3000_0000);
    #1;
    @(posedge clk); #1;
    check(srr1Q[1] == 1'b1, "R10 ri held", {31'b0, srr1Q[1]}, 32'h1);
    checkRegs("R10 R11 hold");

    // R11: synchronous reset clears held state
    @(negedge clk);
    idle();
    rst = 1'b1;
    @(posedge clk); #1;
    expSrr0 = '0; expSrr1 = '0; expMsr = '0;
    checkRegs("R11 reset clear");
    @(negedge clk);
    rst = 1'b0;

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule